// File: doc/BRIEF.md
# Multicycle Instruction Sequencer Control

This block is the control unit of a multicycle processor core. It steps each instruction through a short series of clock cycles: fetch, decode with operand read, execute, an optional memory step and an optional register write-back. In every cycle it drives the datapath's control points: instruction and data memory strobes, load enables for the instruction, operand, result and memory-data registers, the ALU function and second-operand select, and the register-file write controls. It returns to fetch when the instruction is complete. The datapath supplies the opcode and function fields from its instruction register and a zero-compare flag from the ALU.

The machine is Moore-style. Every control point is decoded from the current state and from the ALU function that is captured when decode exits. The single exception is the program-counter write strobe. It merges the unconditional increment issued in decode with a branch-taken term that is gated by the compare flag. Each register transfer takes effect on the clock edge that leaves the state driving it. Arithmetic, OR-immediate and store instructions take four cycles, loads take five and branches take three. An opcode that is not recognised returns to fetch after decode, with no write of any kind.

Top module: `ctl_multicycle`

## Requirements
- R1: A synchronous reset, sampled on a rising edge, puts the machine in fetch (state code 0000). The machine also starts from fetch if reset arrives in the middle of an instruction.
- R2: In fetch, only `imem_rd` and `ir_en` are high. Decode (state code 0001) always follows fetch. In decode, only `a_en`, `b_en` and `pc_load` are high, and `pc_sel` is 0, which selects PC+4.
- R3: Register-register instructions use opcode 0x00 and take 4 cycles. In execute, `s_en` is high, `alu_src` is 0 and `alu_fn` follows the function field: 0x20→0 (add), 0x22→1 (subtract), 0x24→2 (and), 0x25→3 (or), 0x2A→4 (set-less-than). In write-back, `reg_wr` and `reg_dst` are high and `wb_sel` is 0.
- R4: OR-immediate uses opcode 0x0D and takes 4 cycles. In execute, `s_en` is high, `alu_fn` is 3 and `alu_src` is 1 (zero-extended immediate). In write-back, `reg_wr` is high and `reg_dst` and `wb_sel` are 0.
- R5: Load uses opcode 0x23 and takes 5 cycles. In execute, `s_en` is high, `alu_fn` is 0 and `alu_src` is 2 (sign-extended immediate). In the memory step, `dmem_rd` and `m_en` are high. In write-back, `reg_wr` is high, `reg_dst` is 0 and `wb_sel` is 1.
- R6: Store uses opcode 0x2B and takes 4 cycles. Its execute step matches the load's. In the memory step, only `dmem_wr` is high. It never raises `reg_wr`.
- R7: Branch-if-equal uses opcode 0x04 and takes 3 cycles. In execute, `alu_fn` is 1, `alu_src` is 0 and `pc_sel` is 1. `pc_load` equals `equal` in that cycle.
- R8: Any other opcode, or opcode 0x00 with a function code not listed in R3, returns to fetch right after decode (2 cycles) and raises no `s_en`, `reg_wr` or `dmem_wr`.
- R9: After decode, every output except `pc_load` ignores changes on `opcode`, `funct` and `equal`. Outputs not named for a state are 0.
- R10: A ten-instruction mix of 4 ALU, 3 load, 1 store and 2 branch instructions takes 41 cycles, an average of 4.1 cycles per instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| opcode | input | 6 | Opcode field of the instruction register |
| funct | input | 6 | Function field of the instruction register |
| equal | input | 1 | ALU zero-compare flag |
| imem_rd | output | 1 | Instruction memory read |
| ir_en | output | 1 | Instruction register load |
| a_en | output | 1 | Operand A register load |
| b_en | output | 1 | Operand B register load |
| s_en | output | 1 | ALU result register load |
| alu_fn | output | 3 | ALU function code |
| alu_src | output | 2 | Second ALU operand: 0 B, 1 zero-ext imm, 2 sign-ext imm |
| dmem_rd | output | 1 | Data memory read |
| m_en | output | 1 | Memory-data register load |
| dmem_wr | output | 1 | Data memory write |
| reg_wr | output | 1 | Register-file write |
| reg_dst | output | 1 | Destination: 1 rd field, 0 rt field |
| wb_sel | output | 1 | Write-back data: 0 result register, 1 memory-data register |
| pc_sel | output | 1 | PC source: 0 PC+4, 1 branch target |
| pc_load | output | 1 | PC write strobe |
| state_o | output | 4 | Current state code |

## Verification
The hardest case to reach from the ports is proving that nothing after decode listens to the instruction fields. A design that decodes the ALU function from `funct` live, instead of from the captured copy, gives the same outputs whenever the instruction register holds still. To expose this, the stimulus inverts `opcode`, `funct` and `equal` right after the execute cycle is sampled, so every later state sees garbage. It also sweeps all 64 opcodes and all 64 function codes, so every undecoded code has to take the two-cycle return path.

// File: rtl/ctl_pkg.sv
package ctl_pkg;
  parameter int OP_W  = 6;
  parameter int FN_W  = 6;
  parameter int ST_W  = 4;
  parameter int AF_W  = 3;
  parameter int SRC_W = 2;
  localparam int CNT_W = 3;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_EX_ALU = 4'd2,
    S_WB_ALU = 4'd3,
    S_EX_ORI = 4'd4,
    S_WB_ORI = 4'd5,
    S_EX_LW  = 4'd6,
    S_MEM_LW = 4'd7,
    S_WB_LW  = 4'd8,
    S_EX_SW  = 4'd9,
    S_MEM_SW = 4'd10,
    S_EX_BEQ = 4'd11
  } state_t;

  typedef enum logic [2:0] {
    C_ALU = 3'd0, C_ORI = 3'd1, C_LW = 3'd2, C_SW = 3'd3, C_BEQ = 3'd4, C_BAD = 3'd5
  } iclass_t;

  typedef enum logic [AF_W-1:0] {
    F_ADD = 3'd0, F_SUB = 3'd1, F_AND = 3'd2, F_OR = 3'd3, F_SLT = 3'd4
  } alufn_t;

  localparam logic [SRC_W-1:0] SRC_REG = 2'd0;
  localparam logic [SRC_W-1:0] SRC_ZX  = 2'd1;
  localparam logic [SRC_W-1:0] SRC_SX  = 2'd2;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_ORI   = 6'h0D;
  localparam logic [OP_W-1:0] OP_LW    = 6'h23;
  localparam logic [OP_W-1:0] OP_SW    = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  typedef struct packed {
    logic              imem_rd;
    logic              ir_en;
    logic              a_en;
    logic              b_en;
    logic              s_en;
    alufn_t            alu_fn;
    logic [SRC_W-1:0]  alu_src;
    logic              dmem_rd;
    logic              m_en;
    logic              dmem_wr;
    logic              reg_wr;
    logic              reg_dst;
    logic              wb_sel;
    logic              pc_sel;
    logic              pc_inc;
    logic              br_en;
  } ctl_t;

  // {supported, code} for a register-register function field
  function automatic logic [AF_W:0] funct_decode(input logic [FN_W-1:0] fn);
    case (fn)
      FN_ADD:  return {1'b1, F_ADD};
      FN_SUB:  return {1'b1, F_SUB};
      FN_AND:  return {1'b1, F_AND};
      FN_OR:   return {1'b1, F_OR};
      FN_SLT:  return {1'b1, F_SLT};
      default: return {1'b0, F_ADD};
    endcase
  endfunction

  function automatic iclass_t class_of(input logic [OP_W-1:0] op, input logic fn_ok);
    case (op)
      OP_RTYPE: return fn_ok ? C_ALU : C_BAD;
      OP_ORI:   return C_ORI;
      OP_LW:    return C_LW;
      OP_SW:    return C_SW;
      OP_BEQ:   return C_BEQ;
      default:  return C_BAD;
    endcase
  endfunction

  function automatic state_t exec_entry(input iclass_t c);
    case (c)
      C_ALU:   return S_EX_ALU;
      C_ORI:   return S_EX_ORI;
      C_LW:    return S_EX_LW;
      C_SW:    return S_EX_SW;
      C_BEQ:   return S_EX_BEQ;
      default: return S_FETCH;
    endcase
  endfunction

  function automatic logic [CNT_W-1:0] cycles_of(input iclass_t c);
    case (c)
      C_ALU, C_ORI, C_SW: return 3'd4;
      C_LW:               return 3'd5;
      C_BEQ:              return 3'd3;
      default:            return 3'd2;
    endcase
  endfunction
endpackage

// File: rtl/ctl_decode.sv
module ctl_decode
  import ctl_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output iclass_t         cls,
  output alufn_t          rfn,
  output logic            bad
);
  logic [AF_W:0] fdec;

  always_comb begin
    fdec = funct_decode(funct);
    rfn  = alufn_t'(fdec[AF_W-1:0]);
    cls  = class_of(opcode, fdec[AF_W]);
    bad  = (cls == C_BAD);
  end
endmodule

// File: rtl/ctl_next.sv
module ctl_next
  import ctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst,
  input  state_t  st,
  input  iclass_t cls,
  input  logic    bad,
  output state_t  nxt
);
  always_comb begin
    case (st)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: nxt = exec_entry(cls);
      S_EX_ALU: nxt = S_WB_ALU;
      S_EX_ORI: nxt = S_WB_ORI;
      S_EX_LW:  nxt = S_MEM_LW;
      S_MEM_LW: nxt = S_WB_LW;
      S_EX_SW:  nxt = S_MEM_SW;
      default:  nxt = S_FETCH;
    endcase
  end

  p_bad_returns_r8: assert property (@(posedge clk) disable iff (rst)
    (st == S_DECODE && bad) |-> (nxt == S_FETCH));
  p_beq_short_r7: assert property (@(posedge clk) disable iff (rst)
    (st == S_EX_BEQ) |-> (nxt == S_FETCH));
  p_lw_mem_wb_r5: assert property (@(posedge clk) disable iff (rst)
    (st == S_MEM_LW) |-> (nxt == S_WB_LW));
endmodule

// File: rtl/ctl_points.sv
module ctl_points
  import ctl_pkg::*;
(
  input  state_t st,
  input  alufn_t alu_q,
  output ctl_t   ctl
);
  always_comb begin
    ctl = '0;
    case (st)
      S_FETCH: begin
        ctl.imem_rd = 1'b1;
        ctl.ir_en   = 1'b1;
      end
      S_DECODE: begin
        ctl.a_en   = 1'b1;
        ctl.b_en   = 1'b1;
        ctl.pc_inc = 1'b1;
      end
      S_EX_ALU: begin
        ctl.s_en    = 1'b1;
        ctl.alu_fn  = alu_q;
        ctl.alu_src = SRC_REG;
      end
      S_EX_ORI: begin
        ctl.s_en    = 1'b1;
        ctl.alu_fn  = F_OR;
        ctl.alu_src = SRC_ZX;
      end
      S_EX_LW, S_EX_SW: begin
        ctl.s_en    = 1'b1;
        ctl.alu_fn  = F_ADD;
        ctl.alu_src = SRC_SX;
      end
      S_MEM_LW: begin
        ctl.dmem_rd = 1'b1;
        ctl.m_en    = 1'b1;
      end
      S_MEM_SW: ctl.dmem_wr = 1'b1;
      S_WB_ALU: begin
        ctl.reg_wr  = 1'b1;
        ctl.reg_dst = 1'b1;
      end
      S_WB_ORI: ctl.reg_wr = 1'b1;
      S_WB_LW: begin
        ctl.reg_wr = 1'b1;
        ctl.wb_sel = 1'b1;
      end
      S_EX_BEQ: begin
        ctl.alu_fn  = F_SUB;
        ctl.alu_src = SRC_REG;
        ctl.pc_sel  = 1'b1;
        ctl.br_en   = 1'b1;
      end
      default: ctl = '0;
    endcase
  end
endmodule

// File: rtl/ctl_multicycle.sv
module ctl_multicycle
  import ctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic [OP_W-1:0]  opcode,
  input  logic [FN_W-1:0]  funct,
  input  logic             equal,
  output logic             imem_rd,
  output logic             ir_en,
  output logic             a_en,
  output logic             b_en,
  output logic             s_en,
  output logic [AF_W-1:0] alu_fn,
  output logic [SRC_W-1:0] alu_src,
  output logic             dmem_rd,
  output logic             m_en,
  output logic             dmem_wr,
  output logic             reg_wr,
  output logic             reg_dst,
  output logic             wb_sel,
  output logic             pc_sel,
  output logic             pc_load,
  output logic [ST_W-1:0]  state_o
);
  state_t  st, nxt;
  iclass_t cls, cls_q;
  alufn_t  rfn, alu_q;
  logic    bad;
  ctl_t    ctl;
  logic [CNT_W-1:0] cnt;
  logic    instr_end;

  ctl_decode u_dec (.opcode(opcode), .funct(funct), .cls(cls), .rfn(rfn), .bad(bad));
  ctl_next   u_nxt (.clk(clk), .rst(rst), .st(st), .cls(cls), .bad(bad), .nxt(nxt));
  ctl_points u_pts (.st(st), .alu_q(alu_q), .ctl(ctl));

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= S_FETCH;
      alu_q <= F_ADD;
      cls_q <= C_BAD;
      cnt   <= '0;
    end else begin
      st  <= nxt;
      cnt <= (nxt == S_FETCH) ? '0 : cnt + 1'b1;
      if (st == S_DECODE) begin
        alu_q <= rfn;
        cls_q <= cls;
      end
    end
  end

  assign instr_end = (st != S_FETCH) && (nxt == S_FETCH);

  assign imem_rd = ctl.imem_rd;
  assign ir_en   = ctl.ir_en;
  assign a_en    = ctl.a_en;
  assign b_en    = ctl.b_en;
  assign s_en    = ctl.s_en;
  assign alu_fn  = ctl.alu_fn;
  assign alu_src = ctl.alu_src;
  assign dmem_rd = ctl.dmem_rd;
  assign m_en    = ctl.m_en;
  assign dmem_wr = ctl.dmem_wr;
  assign reg_wr  = ctl.reg_wr;
  assign reg_dst = ctl.reg_dst;
  assign wb_sel  = ctl.wb_sel;
  assign pc_sel  = ctl.pc_sel;
  assign pc_load = ctl.pc_inc | (ctl.br_en & equal);
  assign state_o = st;

  p_reset_fetch_r1: assert property (@(posedge clk) rst |=> (st == S_FETCH));
  p_decode_follows_r2: assert property (@(posedge clk) disable iff (rst)
    (st == S_FETCH) |=> (st == S_DECODE));
  p_alu_held_r3: assert property (@(posedge clk) disable iff (rst)
    (st != S_DECODE) |=> $stable(alu_q));
  p_pc_load_src_r7: assert property (@(posedge clk) disable iff (rst)
    pc_load |-> (st == S_DECODE || (st == S_EX_BEQ && equal)));
  p_one_write_r9: assert property (@(posedge clk) disable iff (rst)
    $countones({reg_wr, dmem_wr, ir_en, m_en}) <= 1);
  p_cycle_count_r10: assert property (@(posedge clk) disable iff (rst)
    (instr_end && st != S_DECODE) |-> (cnt + 1'b1 == cycles_of(cls_q)));
endmodule

// File: tb/sim_ctl_multicycle.sv
`timescale 1ns/1ps
module sim_ctl_multicycle;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic [5:0] funct = 6'h20;
  logic equal = 1'b0;
  logic imem_rd, ir_en, a_en, b_en, s_en, dmem_rd, m_en, dmem_wr, reg_wr, reg_dst, wb_sel, pc_sel, pc_load;
  logic [2:0] alu_fn;
  logic [1:0] alu_src;
  logic [3:0] state_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  ctl_multicycle u0 (.clk(clk), .rst(rst), .opcode(opcode), .funct(funct), .equal(equal),
    .imem_rd(imem_rd), .ir_en(ir_en), .a_en(a_en), .b_en(b_en), .s_en(s_en), .alu_fn(alu_fn),
    .alu_src(alu_src), .dmem_rd(dmem_rd), .m_en(m_en), .dmem_wr(dmem_wr), .reg_wr(reg_wr),
    .reg_dst(reg_dst), .wb_sel(wb_sel), .pc_sel(pc_sel), .pc_load(pc_load), .state_o(state_o));

  // classes: 0 alu, 1 ori, 2 load, 3 store, 4 branch, 5 unknown
  function automatic int ref_fn(input logic [5:0] fn);
    case (fn)
      6'h20: return 0;
      6'h22: return 1;
      6'h24: return 2;
      6'h25: return 3;
      6'h2A: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic int ref_class(input logic [5:0] op, input logic [5:0] fn);
    if (op == 6'h00) return (ref_fn(fn) >= 0) ? 0 : 5;
    if (op == 6'h0D) return 1;
    if (op == 6'h23) return 2;
    if (op == 6'h2B) return 3;
    if (op == 6'h04) return 4;
    return 5;
  endfunction

  function automatic int ref_cycles(input int c);
    int t[6] = '{4, 4, 5, 4, 3, 2};
    return t[c];
  endfunction

  function automatic string tag_of(input int c);
    string t[6] = '{"R3", "R4", "R5", "R6", "R7", "R8"};
    return t[c];
  endfunction

  // {imem_rd,ir_en,a_en,b_en,s_en,alu_fn,alu_src,dmem_rd,m_en,dmem_wr,reg_wr,reg_dst,wb_sel,pc_sel,pc_load}
  function automatic logic [17:0] expect_vec(input int c, input int step, input int fcode, input logic eq);
    logic ird = 0, ire = 0, ae = 0, be = 0, se = 0, drd = 0, me = 0, dwr = 0;
    logic rwr = 0, rdst = 0, wsel = 0, psel = 0, pld = 0;
    logic [2:0] fn = 0;
    logic [1:0] src = 0;
    if (step == 0) begin ird = 1; ire = 1; end
    else if (step == 1) begin ae = 1; be = 1; pld = 1; end
    else begin
      case (c)
        0: if (step == 2) begin se = 1; fn = 3'(fcode); end else begin rwr = 1; rdst = 1; end
        1: if (step == 2) begin se = 1; fn = 3; src = 1; end else rwr = 1;
        2: if (step == 2) begin se = 1; src = 2; end
           else if (step == 3) begin drd = 1; me = 1; end
           else begin rwr = 1; wsel = 1; end
        3: if (step == 2) begin se = 1; src = 2; end else dwr = 1;
        4: begin fn = 1; psel = 1; pld = eq; end
        default: ;
      endcase
    end
    return {ird, ire, ae, be, se, fn, src, drd, me, dwr, rwr, rdst, wsel, psel, pld};
  endfunction

  function automatic logic [17:0] actual_vec();
    return {imem_rd, ir_en, a_en, b_en, s_en, alu_fn, alu_src, dmem_rd, m_en, dmem_wr,
            reg_wr, reg_dst, wb_sel, pc_sel, pc_load};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // called at a falling edge while the machine sits in fetch
  task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input logic eq, output int cyc);
    int c = ref_class(op, fn);
    int fc = ref_fn(fn);
    int step = 0;
    opcode = op; funct = fn; equal = eq;
    forever begin
      if (step == 0) check("R2 fetch state", 32'(state_o), 32'd0);
      if (step == 1) check("R2 decode state", 32'(state_o), 32'd1);
      check(step < 2 ? "R2 outputs" : (step > 2 ? {tag_of(c), " R9 outputs"} : {tag_of(c), " outputs"}),
            32'(actual_vec()), 32'(expect_vec(c, step, fc, eq)));
      if (step >= 2) begin opcode = ~op; funct = ~fn; equal = ~eq; end
      @(posedge clk); @(negedge clk);
      step++;
      if (state_o == 4'd0 || step > 8) break;
    end
    cyc = step;
    check({tag_of(c), " cycles"}, 32'(cyc), 32'(ref_cycles(c)));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int cyc, total;
    logic [5:0] mix_op[10] = '{6'h00, 6'h23, 6'h04, 6'h00, 6'h23, 6'h2B, 6'h00, 6'h04, 6'h23, 6'h00};
    logic [5:0] mix_fn[10] = '{6'h20, 6'h00, 6'h00, 6'h22, 6'h00, 6'h00, 6'h24, 6'h00, 6'h00, 6'h2A};
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 reset state", 32'(state_o), 32'd0);
    check("R1 reset outputs", 32'(actual_vec()), 32'(expect_vec(5, 0, 0, 1'b0)));
    // each supported function and both branch outcomes
    run_instr(6'h00, 6'h20, 1'b1, cyc);
    run_instr(6'h00, 6'h22, 1'b0, cyc);
    run_instr(6'h00, 6'h2A, 1'b1, cyc);
    run_instr(6'h0D, 6'h11, 1'b1, cyc);
    run_instr(6'h23, 6'h3F, 1'b1, cyc);
    run_instr(6'h2B, 6'h20, 1'b1, cyc);
    run_instr(6'h04, 6'h00, 1'b1, cyc);
    run_instr(6'h04, 6'h00, 1'b0, cyc);
    // sweep every opcode (R8 for the undecoded ones)
    for (int op = 0; op < 64; op++) run_instr(6'(op), 6'h25, op[0], cyc);
    // sweep every function code under opcode 0x00
    for (int fn = 0; fn < 64; fn++) run_instr(6'h00, 6'(fn), fn[1], cyc);
    // R10: instruction mix
    total = 0;
    for (int i = 0; i < 10; i++) begin
      run_instr(mix_op[i], mix_fn[i], i[0], cyc);
      total += cyc;
    end
    check("R10 mix cycles", 32'(total), 32'd41);
    // R1: reset in the middle of a load
    opcode = 6'h23; funct = 6'h00;
    repeat (3) begin @(posedge clk); @(negedge clk); end
    check("R1 mid-instr pre", 32'(state_o), 32'd7);
    rst = 1'b1;
    @(posedge clk); @(negedge clk);
    rst = 1'b0;
    check("R1 mid-instr state", 32'(state_o), 32'd0);
    check("R1 mid-instr outputs", 32'(actual_vec()), 32'(expect_vec(5, 0, 0, 1'b0)));
    run_instr(6'h23, 6'h00, 1'b0, cyc);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule